// File: doc/BRIEF.md
# Display Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the coordinates of the pixel being shown. It runs one pixel per clock. Each scan line and each frame is split into five consecutive phases: reference-to-sync, sync, back porch, active and front porch. A horizontal position counter steps every clock. A vertical counter steps once per completed line.

Timing is programmed through a small register port. Every timing register holds one horizontal and one vertical value in a single 32-bit word. A second way to load the registers takes classic panel margins: sync lengths, left/right margins and upper/lower margins. From these it derives the register words itself. It forces a one-clock reference-to-sync phase and takes that clock out of the front porch. All writes land in staging registers. They are copied into the working set only when a frame wraps, so a frame never mixes two timings.

Top module: `tg_sync_gen`

## Requirements
- R1: While reset is held and right after it, both counters sit at position 0, which is the reference-to-sync phase. hsync, vsync and de are low, px_x and px_y are 0, and the parameter defaults are the working timing.
- R2: Each line runs through the phases in this order: reference-to-sync, sync, back porch, active, front porch. Each phase lasts its programmed number of clocks, and a programmed 0 counts as 1. hsync is asserted for exactly the horizontal sync phase.
- R3: The vertical position advances by one only on the clock that ends a line. vsync is asserted for every clock of the lines in the vertical sync phase and changes only at line boundaries.
- R4: de is high exactly when both the horizontal and the vertical position are in their active phases.
- R5: px_x is the offset from the first active clock of the line (0 at that clock) and is 0 outside the horizontal active phase. px_y is the offset from the first active line (0 on that line) and is 0 outside the vertical active phase.
- R6: Register address map for wr_addr: 0 reference-to-sync, 1 sync, 2 back porch, 3 front porch, 4 active size. In each of these words bits 15:0 hold the horizontal value and bits 31:16 the vertical value. For address 4 that is the width low and the height high.
- R7: Address 5 is the polarity register. Bit 0 set inverts hsync and bit 1 set inverts vsync; the sync levels stated elsewhere apply with both bits clear.
- R8: A write is stored on the clock edge where wr_en is high. It changes the outputs only from the first clock of the next frame. The frame in progress keeps the old timing. A write on the very edge that wraps the frame waits for the following frame.
- R9: A mg_load pulse writes four registers. Reference-to-sync becomes 1/1. Sync becomes hsync/vsync length. Back porch becomes left/upper margin. Front porch becomes right margin minus 1 / lower margin minus 1, floored at 0. When wr_en targets one of these four registers on the same edge, the load wins.
- R10: An active width above 1366 is used as 1366, and an active height above 768 is used as 768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | 32 | Register write data |
| mg_load | input | 1 | Load timing registers from the margin inputs |
| mg_hsync_len | input | 16 | Horizontal sync length |
| mg_left | input | 16 | Left margin (horizontal back porch) |
| mg_right | input | 16 | Right margin (horizontal front margin) |
| mg_vsync_len | input | 16 | Vertical sync length |
| mg_upper | input | 16 | Upper margin (vertical back porch) |
| mg_lower | input | 16 | Lower margin (vertical front margin) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | 16 | Pixel column inside the active line |
| px_y | output | 16 | Line number inside the active frame |

## Verification
A wrong horizontal position or phase boundary shows at hsync, de or px_x within the line where it occurs. A vertical counter that steps at the wrong time shows up at vsync and px_y no later than the next line boundary. A shadow copy taken at the wrong moment moves the phase edges in the very frame it corrupts. Because every output is compared on every clock against an arithmetic model of the phase layout, such faults are caught in the first cycle they become visible.

// File: rtl/tg_pkg.sv
package tg_pkg;

  localparam int FW = 16;
  localparam int PW = FW + 3;

  typedef enum logic [2:0] {
    PH_REF   = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  typedef struct packed {
    logic [FW-1:0] ref_len;
    logic [FW-1:0] sync_len;
    logic [FW-1:0] back_len;
    logic [FW-1:0] act_len;
    logic [FW-1:0] front_len;
  } axis_cfg_t;

  typedef struct packed {
    logic [PW-1:0] e_ref;
    logic [PW-1:0] e_sync;
    logic [PW-1:0] e_back;
    logic [PW-1:0] e_act;
    logic [PW-1:0] e_tot;
  } axis_bnd_t;

  function automatic logic [FW-1:0] at_least_one(input logic [FW-1:0] v);
    return (v == '0) ? FW'(1) : v;
  endfunction

  function automatic logic [FW-1:0] dec_floor(input logic [FW-1:0] v);
    return (v == '0) ? '0 : v - FW'(1);
  endfunction

  function automatic logic [FW-1:0] cap_at(input logic [FW-1:0] v, input logic [FW-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic axis_bnd_t bounds(input axis_cfg_t c);
    axis_bnd_t b;
    b.e_ref  = PW'(c.ref_len);
    b.e_sync = b.e_ref  + PW'(c.sync_len);
    b.e_back = b.e_sync + PW'(c.back_len);
    b.e_act  = b.e_back + PW'(c.act_len);
    b.e_tot  = b.e_act  + PW'(c.front_len);
    return b;
  endfunction

  function automatic phase_e phase_at(input logic [PW-1:0] p, input axis_bnd_t b);
    if (p < b.e_ref)       return PH_REF;
    else if (p < b.e_sync) return PH_SYNC;
    else if (p < b.e_back) return PH_BACK;
    else if (p < b.e_act)  return PH_ACT;
    else                   return PH_FRONT;
  endfunction

endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
#(
  parameter logic [31:0] DEF_REF   = 32'h0001_0001,
  parameter logic [31:0] DEF_SYNC  = 32'h0002_0060,
  parameter logic [31:0] DEF_BACK  = 32'h0021_0030,
  parameter logic [31:0] DEF_FRONT = 32'h0009_000F,
  parameter logic [31:0] DEF_ACT   = 32'h01E0_0280,
  parameter logic [1:0]  DEF_POL   = 2'b00,
  parameter int unsigned MAX_W     = 1366,
  parameter int unsigned MAX_H     = 768,
  parameter int          AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          mg_load,
  input  logic [FW-1:0] mg_hsync_len,
  input  logic [FW-1:0] mg_left,
  input  logic [FW-1:0] mg_right,
  input  logic [FW-1:0] mg_vsync_len,
  input  logic [FW-1:0] mg_upper,
  input  logic [FW-1:0] mg_lower,
  input  logic          frame_end,
  output axis_cfg_t     h_cfg,
  output axis_cfg_t     v_cfg,
  output logic [1:0]    pol
);

  localparam int NREG   = 5;
  localparam int IX_REF = 0;
  localparam int IX_SYN = 1;
  localparam int IX_BCK = 2;
  localparam int IX_FRT = 3;
  localparam int IX_ACT = 4;
  localparam int IX_POL = 5;
  localparam logic [FW-1:0] LIM_W = FW'(MAX_W);
  localparam logic [FW-1:0] LIM_H = FW'(MAX_H);
  localparam logic [31:0] DEFS [NREG] = '{DEF_REF, DEF_SYNC, DEF_BACK, DEF_FRONT, DEF_ACT};

  logic [31:0] stg     [NREG];
  logic [31:0] stg_nxt [NREG];
  logic [31:0] shd     [NREG];
  logic [1:0]  stg_pol;
  logic [1:0]  shd_pol;

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      stg_nxt[k] = stg[k];
      if (wr_en && (wr_addr == AW'(k))) stg_nxt[k] = wr_data;
    end
    if (mg_load) begin
      stg_nxt[IX_REF] = {FW'(1), FW'(1)};
      stg_nxt[IX_SYN] = {mg_vsync_len, mg_hsync_len};
      stg_nxt[IX_BCK] = {mg_upper, mg_left};
      stg_nxt[IX_FRT] = {dec_floor(mg_lower), dec_floor(mg_right)};
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[k] <= DEFS[k];
        shd[k] <= DEFS[k];
      end else begin
        stg[k] <= stg_nxt[k];
        if (frame_end) shd[k] <= stg[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_pol <= DEF_POL;
      shd_pol <= DEF_POL;
    end else begin
      if (wr_en && (wr_addr == AW'(IX_POL))) stg_pol <= wr_data[1:0];
      if (frame_end) shd_pol <= stg_pol;
    end
  end

  assign h_cfg.ref_len   = at_least_one(shd[IX_REF][FW-1:0]);
  assign h_cfg.sync_len  = at_least_one(shd[IX_SYN][FW-1:0]);
  assign h_cfg.back_len  = at_least_one(shd[IX_BCK][FW-1:0]);
  assign h_cfg.act_len   = at_least_one(cap_at(shd[IX_ACT][FW-1:0], LIM_W));
  assign h_cfg.front_len = at_least_one(shd[IX_FRT][FW-1:0]);
  assign v_cfg.ref_len   = at_least_one(shd[IX_REF][2*FW-1:FW]);
  assign v_cfg.sync_len  = at_least_one(shd[IX_SYN][2*FW-1:FW]);
  assign v_cfg.back_len  = at_least_one(shd[IX_BCK][2*FW-1:FW]);
  assign v_cfg.act_len   = at_least_one(cap_at(shd[IX_ACT][2*FW-1:FW], LIM_H));
  assign v_cfg.front_len = at_least_one(shd[IX_FRT][2*FW-1:FW]);
  assign pol = shd_pol;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(h_cfg) && $stable(v_cfg) && $stable(pol))); // R8

  AST_LEGACY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mg_load |=> (stg[IX_SYN] == {$past(mg_vsync_len), $past(mg_hsync_len)})); // R9

  AST_ACTIVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cfg.act_len <= LIM_W) && (v_cfg.act_len <= LIM_H)); // R10

endmodule

// File: rtl/tg_axis.sv
module tg_axis
  import tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  axis_cfg_t     cfg,
  output phase_e        phase,
  output logic          last,
  output logic [FW-1:0] coord
);

  axis_bnd_t     bnd;
  logic [PW-1:0] pos;

  assign bnd   = bounds(cfg);
  assign last  = (pos >= bnd.e_tot - PW'(1));
  assign phase = phase_at(pos, bnd);
  assign coord = (phase == PH_ACT) ? FW'(pos - bnd.e_back) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= last ? '0 : pos + PW'(1);
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos < bnd.e_tot); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (pos == '0)); // R2

  AST_COORD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_ACT) |-> (coord == '0)); // R5

endmodule

// File: rtl/tg_sync_gen.sv
module tg_sync_gen
  import tg_pkg::*;
#(
  parameter logic [31:0] DEF_REF   = 32'h0001_0001,
  parameter logic [31:0] DEF_SYNC  = 32'h0002_0060,
  parameter logic [31:0] DEF_BACK  = 32'h0021_0030,
  parameter logic [31:0] DEF_FRONT = 32'h0009_000F,
  parameter logic [31:0] DEF_ACT   = 32'h01E0_0280,
  parameter logic [1:0]  DEF_POL   = 2'b00,
  parameter int unsigned MAX_W     = 1366,
  parameter int unsigned MAX_H     = 768,
  parameter int          AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          mg_load,
  input  logic [FW-1:0] mg_hsync_len,
  input  logic [FW-1:0] mg_left,
  input  logic [FW-1:0] mg_right,
  input  logic [FW-1:0] mg_vsync_len,
  input  logic [FW-1:0] mg_upper,
  input  logic [FW-1:0] mg_lower,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] px_x,
  output logic [FW-1:0] px_y
);

  localparam int NAX = 2;

  axis_cfg_t     h_cfg, v_cfg;
  logic [1:0]    pol;
  axis_cfg_t     ax_cfg   [NAX];
  phase_e        ax_ph    [NAX];
  logic [FW-1:0] ax_coord [NAX];
  logic [NAX-1:0] ax_step, ax_last;
  logic          frame_end;

  assign frame_end = ax_last[0] & ax_last[1];

  tg_regs #(
    .DEF_REF(DEF_REF), .DEF_SYNC(DEF_SYNC), .DEF_BACK(DEF_BACK),
    .DEF_FRONT(DEF_FRONT), .DEF_ACT(DEF_ACT), .DEF_POL(DEF_POL),
    .MAX_W(MAX_W), .MAX_H(MAX_H), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mg_load(mg_load),
    .mg_hsync_len(mg_hsync_len), .mg_left(mg_left), .mg_right(mg_right),
    .mg_vsync_len(mg_vsync_len), .mg_upper(mg_upper), .mg_lower(mg_lower),
    .frame_end(frame_end),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .pol(pol)
  );

  assign ax_cfg[0]  = h_cfg;
  assign ax_cfg[1]  = v_cfg;
  assign ax_step[0] = 1'b1;
  assign ax_step[1] = ax_last[0];

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    tg_axis u_axis (
      .clk(clk), .rst_n(rst_n),
      .step(ax_step[a]), .cfg(ax_cfg[a]),
      .phase(ax_ph[a]), .last(ax_last[a]), .coord(ax_coord[a])
    );
  end

  assign hsync = (ax_ph[0] == PH_SYNC) ^ pol[0];
  assign vsync = (ax_ph[1] == PH_SYNC) ^ pol[1];
  assign de    = (ax_ph[0] == PH_ACT) && (ax_ph[1] == PH_ACT);
  assign px_x  = ax_coord[0];
  assign px_y  = ax_coord[1];

  AST_V_STEPS_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    !ax_last[0] |=> ($stable(ax_ph[1]) && $stable(ax_coord[1]))); // R3

  AST_VSYNC_WHOLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !ax_last[0] |=> $stable(vsync)); // R3

  AST_DE_INSIDE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> ((px_x < h_cfg.act_len) && (px_y < v_cfg.act_len))); // R4

  AST_NO_HSYNC_IN_DE: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == pol[0])); // R2

endmodule

// File: tb/tg_sync_gen_test.sv
`timescale 1ns/1ps
module tg_sync_gen_test;

  localparam logic [31:0] D_REF   = 32'h0001_0001;
  localparam logic [31:0] D_SYNC  = 32'h0001_0002;
  localparam logic [31:0] D_BACK  = 32'h0002_0003;
  localparam logic [31:0] D_FRONT = 32'h0001_0002;
  localparam logic [31:0] D_ACT   = 32'h0003_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        mg_load = 1'b0;
  logic [15:0] mg_hsync_len = '0, mg_left = '0, mg_right = '0;
  logic [15:0] mg_vsync_len = '0, mg_upper = '0, mg_lower = '0;
  logic        hsync, vsync, de;
  logic [15:0] px_x, px_y;

  always #2 clk = ~clk;

  tg_sync_gen #(
    .DEF_REF(D_REF), .DEF_SYNC(D_SYNC), .DEF_BACK(D_BACK),
    .DEF_FRONT(D_FRONT), .DEF_ACT(D_ACT), .DEF_POL(2'b00)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mg_load(mg_load), .mg_hsync_len(mg_hsync_len), .mg_left(mg_left),
    .mg_right(mg_right), .mg_vsync_len(mg_vsync_len), .mg_upper(mg_upper),
    .mg_lower(mg_lower), .hsync(hsync), .vsync(vsync), .de(de),
    .px_x(px_x), .px_y(px_y)
  );

  int vectors = 0;
  int fails = 0;
  string ctx = "R1";
  bit done = 0;

  // Model state: phase order ref, sync, back, active, front = words 0,1,2,4,3
  logic [31:0] cur [5];
  logic [31:0] pend [5];
  logic [1:0]  cur_pol, pend_pol;
  int hp = 0, vp = 0;

  function automatic int flen(logic [31:0] w, bit vert, int k);
    int v = vert ? int'(w[31:16]) : int'(w[15:0]);
    if (k == 4) begin
      if (!vert && v > 1366) v = 1366;
      if (vert && v > 768) v = 768;
    end
    if (v == 0) v = 1;
    return v;
  endfunction

  function automatic int word_of(int i);
    return (i == 3) ? 4 : (i == 4) ? 3 : i;
  endfunction

  function automatic int total(bit vert);
    int t = 0;
    for (int k = 0; k < 5; k++) t += flen(cur[k], vert, k);
    return t;
  endfunction

  task automatic locate(input bit vert, input int p, output int ph, output int off);
    int rem = p;
    ph = 4; off = 0;
    for (int i = 0; i < 5; i++) begin
      int w = word_of(i);
      int l = flen(cur[w], vert, w);
      if (rem < l) begin ph = i; off = rem; return; end
      rem -= l;
    end
  endtask

  task automatic compare();
    int hph, hoff, vph, voff;
    logic ehs, evs, ede;
    int ex, ey;
    bit bad = 0;
    locate(1'b0, hp, hph, hoff);
    locate(1'b1, vp, vph, voff);
    ehs = (hph == 1) ^ cur_pol[0];
    evs = (vph == 1) ^ cur_pol[1];
    ede = (hph == 3) && (vph == 3);
    ex  = (hph == 3) ? hoff : 0;
    ey  = (vph == 3) ? voff : 0;
    vectors++;
    if (hsync !== ehs) begin bad = 1;
      $display("FAIL R2 [%s] h=%0d v=%0d hsync got %0b exp %0b", ctx, hp, vp, hsync, ehs); end
    if (vsync !== evs) begin bad = 1;
      $display("FAIL R3 [%s] h=%0d v=%0d vsync got %0b exp %0b", ctx, hp, vp, vsync, evs); end
    if (de !== ede) begin bad = 1;
      $display("FAIL R4 [%s] h=%0d v=%0d de got %0b exp %0b", ctx, hp, vp, de, ede); end
    if (px_x !== 16'(ex) || px_y !== 16'(ey)) begin bad = 1;
      $display("FAIL R5 [%s] h=%0d v=%0d x/y got %0d/%0d exp %0d/%0d", ctx, hp, vp, px_x, px_y, ex, ey); end
    if (bad) fails++;
  endtask

  function automatic logic [15:0] dec0(logic [15:0] v);
    return (v == 0) ? 16'd0 : v - 16'd1;
  endfunction

  task automatic cyc();
    int ht, vt;
    @(posedge clk);
    ht = total(1'b0);
    vt = total(1'b1);
    if (hp == ht - 1) begin
      hp = 0;
      if (vp == vt - 1) begin
        vp = 0;
        for (int k = 0; k < 5; k++) cur[k] = pend[k];
        cur_pol = pend_pol;
      end else vp++;
    end else hp++;
    if (wr_en) begin
      if (wr_addr < 5) pend[wr_addr] = wr_data;
      else if (wr_addr == 5) pend_pol = wr_data[1:0];
    end
    if (mg_load) begin // R9 derivation, load after write so it wins
      pend[0] = 32'h0001_0001;
      pend[1] = {mg_vsync_len, mg_hsync_len};
      pend[2] = {mg_upper, mg_left};
      pend[3] = {dec0(mg_lower), dec0(mg_right)};
    end
    @(negedge clk);
    wr_en = 1'b0;
    mg_load = 1'b0;
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    cur[0] = D_REF; cur[1] = D_SYNC; cur[2] = D_BACK; cur[3] = D_FRONT; cur[4] = D_ACT;
    for (int k = 0; k < 5; k++) pend[k] = cur[k];
    cur_pol = 2'b00; pend_pol = 2'b00;
    repeat (3) @(negedge clk);
    ctx = "R1"; compare();           // R1 reset state
    rst_n = 1'b1;
    ctx = "R2"; run(2 * 96);         // R2 R3 R4 R5 default 12x8 frame
    ctx = "R6/R8";
    run(30);                         // R8 mid-frame writes
    wr(3'd1, 32'h0002_0003);         // R6 sync: v=2, h=3
    wr(3'd2, 32'h0001_0000);         // R2 zero horizontal back porch counts as 1
    wr(3'd4, 32'h0002_0005);         // R6 active: height 2, width 5
    run(320);
    ctx = "R7";
    wr(3'd5, 32'h0000_0003);         // R7 invert both syncs
    run(250);
    wr(3'd5, 32'h0000_0001);         // R7 invert hsync only
    run(200);
    ctx = "R9";
    mg_hsync_len = 16'd1; mg_left = 16'd2; mg_right = 16'd1;
    mg_vsync_len = 16'd2; mg_upper = 16'd1; mg_lower = 16'd3;
    mg_load = 1'b1;
    wr(3'd1, 32'h0007_0007);         // R9 same-edge write to sync loses
    run(300);
    ctx = "R10";
    wr(3'd4, {16'd2, 16'd2000});     // R10 width capped to 1366
    run(20000);
    wr(3'd4, {16'd800, 16'd1});      // R10 height capped to 768
    run(12000);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog [%s] run did not complete got timeout exp completion", ctx);
      summary();
      $finish;
    end
  end

endmodule